// File: doc/BRIEF.md
# DCC Packet Bit Framer

The framer sits between a host that assembles complete track packets and a waveform stage that shapes the signal on the rails. The host hands over between one and six bytes together with a byte count and a one-cycle load strobe. The bytes must already include the checksum. The framer stores the packet and frames it into the logical bit sequence that the track protocol expects. That sequence is a run of fourteen ones, then each byte preceded by a single zero, then a final one.

The waveform stage pulls bits one at a time. At the start of every bit cell it raises `bit_req_i` for one clock. The framer presents the bit for that cell on `bit_o` during the same cycle and advances on the clock edge. When no packet is waiting, every requested bit is a one, so the rails never go unpowered. `busy_o` tells the host when it may load the next packet. A packet loaded as soon as `busy_o` drops goes out with a full preamble of its own.

Top module: `dcc_bit_framer`

## Requirements
- R1: While `busy_o` is low, every requested bit is a one (`bit_o` = 1 whenever `bit_req_i` is high).
- R2: The first request after an accepted load returns the first of exactly 14 one bits, with no idle bit inserted before it.
- R3: A single zero bit comes right before each data byte, including the first.
- R4: Each byte goes out as eight bits, most significant bit first. Byte k is taken from `data_i[8k+7:8k]`, in order from k = 0 upward.
- R5: After the last data bit, one closing one bit is sent. `busy_o` is high from the cycle after an accepted load until the clock edge that consumes the closing bit, so a packet of n bytes is 15 + 9n requests long.
- R6: A load is accepted only when `count_i` is between 1 and 6, and exactly `count_i` bytes are sent. A count of 0 or above 6 is ignored: `busy_o` stays low and only ones follow.
- R7: While `busy_o` is high, a load strobe is ignored. Once a load is accepted, changes on `data_i` have no effect on the packet being sent.
- R8: Packets loaded back to back each begin with their own full 14-bit preamble.
- R9: Without a request, the framer does not advance: `bit_o` and `busy_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that offers a packet |
| count_i | input | 3 | Number of bytes in the offered packet |
| data_i | input | 48 | Packet bytes; byte k is at bits 8k+7:8k |
| busy_o | output | 1 | A packet is pending or being framed |
| bit_req_i | input | 1 | Waveform stage asks for the next bit |
| bit_o | output | 1 | Logical bit for the requested cell |

## Verification
The hardest case to reach from the ports is a load strobe that arrives while a packet is in flight, combined with a host that changes its buffer at the same moment. The bench covers this by loading a packet, then at once driving different bytes and a different count with a second strobe while `busy_o` is high. It then checks that every bit of the stream still matches the first packet. Stalls between requests are put in the middle of preamble, separator and data bits to show that the framer holds its position.

// File: rtl/dcc_framer_pkg.sv
package dcc_framer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_START,
    ST_DATA,
    ST_STOP
  } fr_state_e;
endpackage

// File: rtl/dcc_load_ctl.sv
module dcc_load_ctl #(
  parameter int MAX_BYTES = 6,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             active_i,
  input  logic             take_i,
  output logic             accept_o,
  output logic             pend_o
);
  logic pend_q;

  assign accept_o = load_i && !pend_q && !active_i && (count_i != '0)
                    && (int'(count_i) <= MAX_BYTES);
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (accept_o) pend_q <= 1'b1;
    else if (take_i)   pend_q <= 1'b0;
  end
endmodule

// File: rtl/dcc_pkt_store.sv
module dcc_pkt_store #(
  parameter int MAX_BYTES = 6,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_en_i,
  input  logic [MAX_BYTES*8-1:0] data_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [IDX_W-1:0]       byte_idx_i,
  input  logic [2:0]             bit_idx_i,
  output logic                   bit_o,
  output logic                   last_byte_o
);
  logic [7:0]       bytes_q [MAX_BYTES];
  logic [CNT_W-1:0] count_q;
  logic [7:0]       sel_byte;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bytes_q[k] <= '0;
      else if (load_en_i) bytes_q[k] <= data_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (load_en_i) count_q <= count_i;
  end

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (byte_idx_i == IDX_W'(k)) sel_byte = bytes_q[k];
  end

  assign bit_o       = sel_byte[bit_idx_i];
  assign last_byte_o = (CNT_W'(byte_idx_i) + CNT_W'(1)) == count_q;
endmodule

// File: rtl/dcc_seq_fsm.sv
module dcc_seq_fsm
  import dcc_framer_pkg::*;
#(
  parameter int PRE_LEN   = 14,  // must be >= 2
  parameter int MAX_BYTES = 6,
  localparam int PRE_W = $clog2(PRE_LEN + 1),
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             pend_i,
  input  logic             last_byte_i,
  input  logic             data_bit_i,
  output logic             take_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [2:0]       bit_idx_o,
  output logic             bit_o,
  output logic             active_o
);
  fr_state_e        state_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [2:0]       bit_cnt_q;
  logic [IDX_W-1:0] byte_idx_q;

  assign take_o     = req_i && (state_q == ST_IDLE) && pend_i;
  assign byte_idx_o = byte_idx_q;
  assign bit_idx_o  = bit_cnt_q;
  assign active_o   = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: bit_o = 1'b0;
      ST_DATA:  bit_o = data_bit_i;
      default:  bit_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pre_cnt_q  <= PRE_W'(PRE_LEN);
      bit_cnt_q  <= 3'd7;
      byte_idx_q <= '0;
    end else if (req_i) begin
      unique case (state_q)
        ST_IDLE: if (pend_i) begin
          // first preamble bit issued in this very request
          pre_cnt_q <= PRE_W'(PRE_LEN - 1);
          state_q   <= ST_PRE;
        end
        ST_PRE: begin
          pre_cnt_q <= pre_cnt_q - PRE_W'(1);
          if (pre_cnt_q == PRE_W'(1)) state_q <= ST_START;
        end
        ST_START: begin
          bit_cnt_q <= 3'd7;
          state_q   <= ST_DATA;
        end
        ST_DATA: begin
          bit_cnt_q <= bit_cnt_q - 3'd1;
          if (bit_cnt_q == 3'd0) begin
            if (last_byte_i) state_q <= ST_STOP;
            else begin
              byte_idx_q <= byte_idx_q + IDX_W'(1);
              state_q    <= ST_START;
            end
          end
        end
        ST_STOP: begin
          pre_cnt_q  <= PRE_W'(PRE_LEN);
          byte_idx_q <= '0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcc_bit_framer.sv
module dcc_bit_framer #(
  parameter int MAX_BYTES = 6,
  parameter int PRE_LEN   = 14,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [MAX_BYTES*8-1:0] data_i,
  output logic                   busy_o,
  input  logic                   bit_req_i,
  output logic                   bit_o
);
  logic             accept, pend, take, active, data_bit, last_byte;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_idx;

  dcc_load_ctl #(.MAX_BYTES(MAX_BYTES)) u_load (
    .clk_i, .rst_ni, .load_i, .count_i,
    .active_i(active), .take_i(take), .accept_o(accept), .pend_o(pend)
  );

  dcc_pkt_store #(.MAX_BYTES(MAX_BYTES)) u_store (
    .clk_i, .rst_ni, .load_en_i(accept), .data_i, .count_i,
    .byte_idx_i(byte_idx), .bit_idx_i(bit_idx),
    .bit_o(data_bit), .last_byte_o(last_byte)
  );

  dcc_seq_fsm #(.PRE_LEN(PRE_LEN), .MAX_BYTES(MAX_BYTES)) u_fsm (
    .clk_i, .rst_ni, .req_i(bit_req_i), .pend_i(pend),
    .last_byte_i(last_byte), .data_bit_i(data_bit), .take_o(take),
    .byte_idx_o(byte_idx), .bit_idx_o(bit_idx), .bit_o, .active_o(active)
  );

  assign busy_o = pend | active;
endmodule

// File: rtl/dcc_bit_framer_chk.sv
module dcc_bit_framer_chk #(
  parameter int MAX_BYTES = 6,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [CNT_W-1:0] count_i,
  input logic             busy_o,
  input logic             bit_req_i,
  input logic             bit_o
);
  assert_idle_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && bit_req_i) |-> bit_o);

  assert_close_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(bit_req_i) && $past(bit_o)));

  assert_valid_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(load_i) && $past(count_i) != '0
                       && int'($past(count_i)) <= MAX_BYTES));

  assert_zero_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && count_i == '0) |=> !busy_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_req_i) |=> (busy_o && $stable(bit_o)));
endmodule

bind dcc_bit_framer dcc_bit_framer_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .count_i(count_i),
  .busy_o(busy_o), .bit_req_i(bit_req_i), .bit_o(bit_o)
);

// File: tb/dcc_bit_framer_tb.sv
`timescale 1ns/1ps
module dcc_bit_framer_tb;
  localparam real CLK_PERIOD = 8.0;
  localparam int  PRE = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  count = '0;
  logic [47:0] data = '0;
  logic        busy, req = 1'b0, bit_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_bit_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .count_i(count),
    .data_i(data), .busy_o(busy), .bit_req_i(req), .bit_o(bit_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_load(input int n, input logic [47:0] d);
    @(negedge clk);
    load = 1'b1; count = 3'(n); data = d;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  task automatic req_bit(output logic b);
    @(negedge clk);
    req = 1'b1; #1;
    b = bit_out;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  function automatic logic exp_bit(int i, int n, logic [47:0] d);
    int j, k, p;
    if (i < PRE) return 1'b1;
    j = i - PRE;
    if (j < 9*n) begin
      k = j / 9; p = j % 9;
      if (p == 0) return 1'b0;
      return d[8*k + (8-p)];
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(int i, int n, bit later);
    int j;
    if (i < PRE) return later ? "R2 R8 preamble" : "R2 preamble";
    j = i - PRE;
    if (j < 9*n) return (j % 9 == 0) ? "R3 start bit" : "R4 data bit";
    return "R5 closing bit";
  endfunction

  // stream one packet; optionally stall mid-stream or try to disturb it
  task automatic run_packet(input int n, input logic [47:0] d, input bit stall,
                            input bit disturb, input bit later);
    int total = 15 + 9*n;
    logic b;
    pulse_load(n, d);
    chk(busy === 1'b1, "R5 busy after load", busy, 1);
    if (disturb) begin
      pulse_load(3, ~d);
      @(negedge clk); data = 48'h5A5A_1234_9876;
      chk(busy === 1'b1, "R7 busy after ignored load", busy, 1);
    end
    for (int i = 0; i < total; i++) begin
      if (stall && (i % 7 == 3)) begin
        repeat (2) @(negedge clk);
        #1;
        chk(bit_out === exp_bit(i, n, d), "R9 held bit", bit_out, exp_bit(i, n, d));
        chk(busy === 1'b1, "R9 held busy", busy, 1);
      end
      req_bit(b);
      chk(b === exp_bit(i, n, d), disturb ? "R7 stream" : tag_of(i, n, later),
          b, exp_bit(i, n, d));
      chk(busy === (i < total-1), "R5 R6 busy span", busy, int'(i < total-1));
    end
  endtask

  function automatic logic [47:0] pattern(int p, int n);
    logic [47:0] d = '0;
    for (int k = 0; k < 6; k++) begin
      case (p)
        0: d[8*k +: 8] = 8'h00;
        1: d[8*k +: 8] = 8'hFF;
        2: d[8*k +: 8] = (k % 2) ? 8'h5A : 8'hA5;
        default: d[8*k +: 8] = 8'((k*53 + n*29 + 17) ^ (k << 4));
      endcase
    end
    return d;
  endfunction

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(bit_out === 1'b1, "R1 reset bit", bit_out, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      req_bit(b);
      chk(b === 1'b1, "R1 idle one", b, 1);
    end
    // sweep byte counts and patterns; packets follow each other directly
    for (int n = 1; n <= 6; n++)
      for (int p = 0; p < 4; p++)
        run_packet(n, pattern(p, n), p == 3, 1'b0, (n*4 + p) > 4);
    // load ignored while busy, buffer changes ignored
    run_packet(2, 48'h0000_0000_C3_96, 1'b1, 1'b1, 1'b1);
    // invalid counts
    for (int c = 0; c <= 7; c += 7) begin
      pulse_load(c, 48'hFFFF_FFFF_FFFF);
      chk(busy === 1'b0, "R6 invalid count ignored", busy, 0);
      for (int i = 0; i < 20; i++) begin
        req_bit(b);
        chk(b === 1'b1, "R6 R1 ones after invalid load", b, 1);
      end
      chk(busy === 1'b0, "R6 stays idle", busy, 0);
    end
    // full size packet after idle time
    run_packet(6, 48'h0102_8040_7FE1, 1'b0, 1'b0, 1'b1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule